// File: doc/BRIEF.md
# Serial Bus Error Flag Register

This block holds the error status byte of a byte-level serial bus decoder. The receiver and transmitter raise one-cycle event pulses when a received byte is ready, a transmit request is aborted, a CRC check fails or a frame is invalid. They also raise a level that is high while a break symbol is on the bus. Each event sets a sticky flag. The CPU reads all flags as one byte through a read-data port. A one-cycle read strobe marks the read and applies the clear-on-read rules.

Each flag has its own clear rule. The overflow flag is cleared by a read that found it set. The transmit-abort flag ignores reads. The break flag cannot be cleared while the break level is still high. The CRC and invalid-frame flags clear on any read. A low enable bit or a high disable bit holds every flag at zero and causes events to be ignored. To detect overflow, the block tracks whether the receive data register holds a byte the CPU has not read. A byte-ready pulse fills that register and a receive-data read empties it.

Top module: `bus_err_flags`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and the receive data register counts as empty.
- R2: Overflow flag (bit 5) is set when `byte_rdy` pulses while the receive data register holds an unread byte and `rx_rd` is low in that cycle. A `byte_rdy` pulse fills the register and an `rx_rd` pulse empties it.
- R3: A status read (`rd_stb`) made while the overflow flag is set clears it. A read made while the flag is clear does not affect a later overflow.
- R4: Transmit-abort flag (bit 4) is set by `abort_evt` and is not cleared by status reads.
- R5: Break flag (bit 3) is set while `brk_det` is high and stays set through status reads made while `brk_det` is high.
- R6: Once `brk_det` is low, the next status read clears the break flag.
- R7: CRC flag (bit 2) and invalid-frame flag (bit 1) are set by `crc_evt` and `ifd_evt` and are cleared by any status read.
- R8: If a set condition and a clearing read fall in the same cycle, the flag ends up set.
- R9: `rd_data` shows the flags in the current cycle, before that cycle's read takes effect. Bits 7, 6 and 0 are always zero.
- R10: While `en` is low or `dis` is high, every flag is held at zero, the receive data register counts as empty, and events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Decoder enable; low holds all flags clear |
| dis | input | 1 | Decoder disable; high holds all flags clear |
| byte_rdy | input | 1 | Pulse: a received byte moves into the receive data register |
| rx_rd | input | 1 | Pulse: CPU reads the receive data register |
| abort_evt | input | 1 | Pulse: a transmit request was aborted |
| brk_det | input | 1 | Level: a break symbol is present on the bus |
| crc_evt | input | 1 | Pulse: received CRC check failed |
| ifd_evt | input | 1 | Pulse: invalid frame detected |
| rd_stb | input | 1 | One-cycle status register read strobe |
| rd_data | output | 8 | Status byte |

## Verification
A status read can fall in the same cycle as a set event. Two cases matter: a CRC or invalid-frame pulse arriving during a read, and a new overflow arriving during the read that would otherwise clear the old one. The bench sweeps every combination of the event inputs, the read strobe and the hold control, one combination per cycle. It presents the combinations in a scrambled order, so each one meets many different prior flag states. After each cycle it compares the status byte with a model built from the requirements. A directed sequence holds the break level high across several reads, then releases it and reads again.

// File: rtl/bus_err_flags.sv
module bus_err_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       dis,
  input  logic       byte_rdy,
  input  logic       rx_rd,
  input  logic       abort_evt,
  input  logic       brk_det,
  input  logic       crc_evt,
  input  logic       ifd_evt,
  input  logic       rd_stb,
  output logic [7:0] rd_data
);

  logic hold;
  logic rx_full, ovf, tra, brk, crc, ifd;
  logic ovf_hit;

  assign hold    = !en || dis;
  assign ovf_hit = byte_rdy && rx_full && !rx_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      ovf     <= 1'b0;
      tra     <= 1'b0;
      brk     <= 1'b0;
      crc     <= 1'b0;
      ifd     <= 1'b0;
    end else if (hold) begin
      rx_full <= 1'b0;
      ovf     <= 1'b0;
      tra     <= 1'b0;
      brk     <= 1'b0;
      crc     <= 1'b0;
      ifd     <= 1'b0;
    end else begin
      rx_full <= byte_rdy || (rx_full && !rx_rd);
      ovf     <= ovf_hit  || (ovf && !rd_stb);
      tra     <= abort_evt || tra;
      brk     <= brk_det  || (brk && !rd_stb);
      crc     <= crc_evt  || (crc && !rd_stb);
      ifd     <= ifd_evt  || (ifd && !rd_stb);
    end
  end

  assign rd_data = {2'b00, ovf, tra, brk, crc, ifd, 1'b0};

  a_r10_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (rd_data == 8'h00));

  a_r4_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && rd_data[4]) |=> rd_data[4]);

  a_r5_break_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && brk_det) |=> rd_data[3]);

  a_r8_crc_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && crc_evt && rd_stb) |=> rd_data[2]);

  a_r3_ovf_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && rd_stb && rd_data[5] && !byte_rdy) |=> !rd_data[5]);

endmodule

// File: tb/bus_err_flags_tb.sv
module bus_err_flags_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, dis = 1'b0, byte_rdy = 1'b0, rx_rd = 1'b0, abort_evt = 1'b0;
  logic brk_det = 1'b0, crc_evt = 1'b0, ifd_evt = 1'b0, rd_stb = 1'b0;
  logic [7:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit m_full, m_ovf, m_tra, m_brk, m_crc, m_ifd;

  always #5 clk = ~clk;

  bus_err_flags u_dut (.*);

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_byte();
    return {2'b00, m_ovf, m_tra, m_brk, m_crc, m_ifd, 1'b0};
  endfunction

  // v = {byte_rdy, rx_rd, abort, brk, crc, ifd, rd, hold}; mode picks en-low or dis-high
  task automatic step(input logic [7:0] v, input bit mode, input string tag);
    bit h, nov;
    byte_rdy = v[7]; rx_rd = v[6]; abort_evt = v[5]; brk_det = v[4];
    crc_evt = v[3]; ifd_evt = v[2]; rd_stb = v[1];
    en  = mode ? 1'b1 : !v[0];
    dis = mode ? v[0] : 1'b0;
    chk({tag, " R9 pre-read view"}, rd_data, m_byte());
    @(posedge clk);
    h = v[0];
    if (h) begin
      {m_full, m_ovf, m_tra, m_brk, m_crc, m_ifd} = '0;
    end else begin
      nov    = (v[7] && m_full && !v[6]) || (m_ovf && !v[1]);
      m_full = v[7] || (m_full && !v[6]);
      m_ovf  = nov;
      m_tra  = m_tra || v[5];
      m_brk  = v[4] || (m_brk && !v[1]);
      m_crc  = v[3] || (m_crc && !v[1]);
      m_ifd  = v[2] || (m_ifd && !v[1]);
    end
    @(negedge clk);
    chk(tag, rd_data, m_byte());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset value", rd_data, 8'h00);
    rst_n = 1'b1;
    en = 1'b1;
    @(negedge clk);
    chk("R1 after release", rd_data, 8'h00);

    // R2: fill, then overflow
    step(8'h80, 0, "R2 fill");
    step(8'h80, 0, "R2 overflow");
    chk("R2 bit5", rd_data & 8'h20, 8'h20);
    // R8: new overflow during clearing read
    step(8'h82, 0, "R8 ovf set wins");
    chk("R8 ovf still set", rd_data & 8'h20, 8'h20);
    // R3: plain read clears
    step(8'h02, 0, "R3 read clears ovf");
    chk("R3 bit5 clear", rd_data & 8'h20, 8'h00);
    // R4
    step(8'h20, 0, "R4 abort set");
    step(8'h02, 0, "R4 read keeps abort");
    chk("R4 bit4", rd_data & 8'h10, 8'h10);
    // R7 and R8 for crc/ifd
    step(8'h0C, 0, "R7 set crc ifd");
    chk("R7 bits", rd_data & 8'h06, 8'h06);
    step(8'h0A, 0, "R8 crc during read");
    chk("R8 crc kept ifd cleared", rd_data & 8'h06, 8'h04);
    // R5/R6 break
    for (int k = 0; k < 3; k++) step(8'h12, 0, "R5 break through reads");
    chk("R5 bit3", rd_data & 8'h08, 8'h08);
    step(8'h00, 0, "R6 break gone");
    chk("R6 still set before read", rd_data & 8'h08, 8'h08);
    step(8'h02, 0, "R6 read after break");
    chk("R6 bit3 clear", rd_data & 8'h08, 8'h00);
    // R10 both hold sources
    step(8'hBD, 0, "R10 en low");
    chk("R10 en low zero", rd_data, 8'h00);
    step(8'h3C, 0, "R7 refill");
    step(8'hBD, 1, "R10 dis high");
    chk("R10 dis high zero", rd_data, 8'h00);

    // sweep of all combinations, scrambled order
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 256; i++)
        step(8'((i * 37 + p * 91 + 11) & 8'hFF), p[0], "R2 R3 R5 R7 R8 R10 sweep");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule